// File: doc/BRIEF.md
# Pairwise Widening Vector Adder

This unit takes one packed vector word and adds every two neighbouring elements together, writing each sum into a result lane that is twice as wide as the source elements. The result word therefore has the same total width as the operand but half as many lanes. Because each lane is double width, no sum can overflow, and no saturation or carry-out is needed.

A two-bit mode selects the element width (bytes or halfwords) and whether elements are read as two's complement or as plain unsigned values. The operand and mode are captured on a clock edge where `in_valid` is high. The widened result and `out_valid` appear on the following edge. While `in_valid` stays low, the previous result is held.

Top module: `pairwise_widen_add`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Reset drives `out_valid` and `result` to zero.
- R2: Mode bit 0 set means signed elements; mode bit 1 set means 16-bit source elements. Mode 2'b00 is unsigned 8-bit, 2'b01 signed 8-bit, 2'b10 unsigned 16-bit and 2'b11 signed 16-bit.
- R3: In unsigned 8-bit mode, result bits [16k+15:16k] equal the zero-extended sum of operand bytes [16k+7:16k] and [16k+15:16k+8], for k = 0..3.
- R4: In signed 8-bit mode, each 16-bit lane k holds the two's complement sum of the same two bytes, each sign-extended to 16 bits first.
- R5: In unsigned 16-bit mode, result bits [32k+31:32k] equal the zero-extended sum of halfwords [32k+15:32k] and [32k+31:32k+16], for k = 0..1.
- R6: In signed 16-bit mode, each 32-bit lane holds the two's complement sum of the two sign-extended halfwords.
- R7: Every lane holds the exact sum with no wrap. For example, bytes 0xFF+0xFF give 0x01FE unsigned; bytes 0x80+0x80 give 0xFF00 signed; halfwords 0x8000+0x8000 give 0xFFFF0000 signed; halfwords 0xFFFF+0xFFFF give 0x0001FFFE unsigned.
- R8: In a cycle where `in_valid` is low, `result` keeps its value, whatever `operand` and `mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture operand and mode this edge |
| mode | input | 2 | Bit 0 signed, bit 1 halfword elements |
| operand | input | 64 | Packed source vector |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 64 | Packed widened pair sums |

## Verification
The hardest case to reach is the boundary where the sign-extended bits of an element decide the top of the lane. Only mixed extreme elements show this, such as 0x80 next to 0x7F, or 0xFF next to 0x80 read as signed. Uniform patterns hide a wrong extension width. The stimulus therefore sends each corner value, and mixtures of them, through all four modes back to back. It changes the mode on every transfer and inserts idle cycles with a changing operand to expose any leak into the held result.

// File: rtl/pairwise_widen_add.sv
module pairwise_widen_add #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;
  localparam int LANES_B = DATA_W / (2*BYTE_W);
  localparam int LANES_H = DATA_W / (2*HALF_W);

  logic              is_signed;
  logic              is_half;
  logic [DATA_W-1:0] sum_b;
  logic [DATA_W-1:0] sum_h;

  assign is_signed = mode[0];
  assign is_half   = mode[1];

  for (genvar k = 0; k < LANES_B; k++) begin : g_byte
    logic [BYTE_W-1:0]   lo, hi;
    logic [2*BYTE_W-1:0] lo_x, hi_x;
    assign lo   = operand[2*BYTE_W*k +: BYTE_W];
    assign hi   = operand[2*BYTE_W*k+BYTE_W +: BYTE_W];
    assign lo_x = {{BYTE_W{is_signed & lo[BYTE_W-1]}}, lo};
    assign hi_x = {{BYTE_W{is_signed & hi[BYTE_W-1]}}, hi};
    assign sum_b[2*BYTE_W*k +: 2*BYTE_W] = lo_x + hi_x;
  end

  for (genvar k = 0; k < LANES_H; k++) begin : g_half
    logic [HALF_W-1:0]   lo, hi;
    logic [2*HALF_W-1:0] lo_x, hi_x;
    assign lo   = operand[2*HALF_W*k +: HALF_W];
    assign hi   = operand[2*HALF_W*k+HALF_W +: HALF_W];
    assign lo_x = {{HALF_W{is_signed & lo[HALF_W-1]}}, lo};
    assign hi_x = {{HALF_W{is_signed & hi[HALF_W-1]}}, hi};
    assign sum_h[2*HALF_W*k +: 2*HALF_W] = lo_x + hi_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= is_half ? sum_h : sum_b;
    end
  end
endmodule

// File: rtl/pairwise_widen_add_chk.sv
module pairwise_widen_add_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (result[15:9] == 7'd0 && result[31:25] == 7'd0));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> (result[31:17] == 15'd0 && result[63:49] == 15'd0));
  a_r4_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (result[15:8] == 8'h00 || result[15:8] == 8'hFF ||
                                     result[15:9] == 7'h00 || result[15:9] == 7'h7F));
endmodule

bind pairwise_widen_add pairwise_widen_add_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_pairwise_widen_add.sv
module tb_pairwise_widen_add;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [63:0] m_result = '0;
  logic        m_valid = 1'b0;
  string       m_tag = "R1";
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  pairwise_widen_add dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .operand(operand), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_sum(input logic [63:0] op, input logic [1:0] md);
    int w = md[1] ? 16 : 8;
    int lanes = 64 / (2*w);
    longint unsigned emask = (longint'(1) << w) - 1;
    longint unsigned lmask = (w == 16) ? 64'hFFFF_FFFF : 64'hFFFF;
    logic [63:0] r = '0;
    for (int k = 0; k < lanes; k++) begin
      longint a = longint'((op >> (2*w*k)) & emask);
      longint b = longint'((op >> (2*w*k + w)) & emask);
      if (md[0] && a >= (longint'(1) << (w-1))) a -= (longint'(1) << w);
      if (md[0] && b >= (longint'(1) << (w-1))) b -= (longint'(1) << w);
      r |= ((a + b) & lmask) << (2*w*k);
    end
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b00: return "R2 R3";
      2'b01: return "R2 R4";
      2'b10: return "R2 R5";
      default: return "R2 R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_result <= '0;
      m_tag    <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_result <= ref_sum(operand, mode);
        m_tag    <= mode_tag(mode);
      end else begin
        m_tag    <= "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid === m_valid, "R1", {63'd0, out_valid}, {63'd0, m_valid});
      check(result === m_result, m_tag, result, m_result);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [1:0] md, input logic [63:0] op);
    @(negedge clk);
    in_valid = 1'b1; mode = md; operand = op;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      operand = ~operand ^ 64'h5A5A_0F0F_3C3C_9696;
      mode = mode + 2'd1;
    end
  endtask

  task automatic direct(input logic [1:0] md, input logic [63:0] op, input logic [63:0] exp);
    send(md, op);
    @(negedge clk);
    in_valid = 1'b0;
    check(result === exp, "R7", result, exp);
  endtask

  logic [63:0] corners [8] = '{64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F,
                               64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000,
                               64'h807F_FF80_7FFF_0080, 64'h7FFF_8000_FFFF_0001,
                               64'h0000_0000_0000_0000, 64'hFF80_807F_8000_7FFF};

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset", {63'd0, out_valid}, 64'd0);
    check(result === 64'd0, "R1 reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 exact extremes
    direct(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h01FE_01FE_01FE_01FE);
    direct(2'b01, 64'h8080_8080_8080_8080, 64'hFF00_FF00_FF00_FF00);
    direct(2'b11, 64'h8000_8000_8000_8000, 64'hFFFF_0000_FFFF_0000);
    direct(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_FFFE_0001_FFFE);
    direct(2'b01, 64'h7F7F_7F7F_7F7F_7F7F, 64'h00FE_00FE_00FE_00FE);
    direct(2'b01, 64'h807F_807F_FF80_FF80, 64'hFFFF_FFFF_FF7F_FF7F);

    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++) send(2'(m), corners[c]);
    idle(3);
    for (int c = 0; c < 8; c++) begin
      for (int m = 3; m >= 0; m--) begin
        send(2'(m), corners[c] ^ corners[(c+3)%8]);
        idle(1);
      end
    end
    for (int i = 0; i < 400; i++) begin
      seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
      if (seed[5:4] == 2'b00) idle(1);
      else send(seed[1:0], seed);
    end
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule